// File: doc/BRIEF.md
# Voltage-code reference slew generator

This block turns a voltage-identification code into a digital reference target. It then moves a live reference value toward that target at a fixed, bounded rate. Two code tables are built in, selected by a mode input:

- **Serial table:** a 7-bit linear table with an off region at its top.
- **Parallel table:** a 6-bit piecewise table, with a coarse step in its upper voltage half and a fine step in its lower half.

The reference is expressed in units of 0.5 mV and feeds a downstream DAC and error amplifier, which are outside this block.

A new code and mode are captured only on a load strobe. The reference moves only on a one-microsecond tick, by 3.25 mV per tick, using a half-unit accumulator. This covers every case:

- soft-start from zero after enable;
- every later code change;
- the ramp back down to zero when enable drops or an off code is selected.

The load strobe is a plain control pin. It is always accepted in the cycle it is high, and there is no back-pressure.

Top module: `vid_ref_ramp`

## Requirements
- R1: After reset the reference is 0, and with enable low the off flag is 1 and the at-target flag is 0.
- R2: In serial mode (mode=0), codes 0..123 decode to 3100 − 25×code units (1.5500 V down to 12.5 mV), so code 123 gives 25.
- R3: In serial mode, codes 124..127 select off: the reference ramps to 0 and the off flag then rises. In parallel mode these same code values are ordinary codes.
- R4: In parallel mode (mode=1, code bits 5:0 used), codes 0..31 decode to 3100 − 50×code units, so code 31 gives 1550.
- R5: In parallel mode, codes 32..63 decode to 1525 − 25×(code−32) units, so code 63 gives 750.
- R6: Each tick moves the internal half-unit reference by exactly 13 half-units (3.25 mV) toward the goal. The output is that value shifted right by one.
- R7: Without a tick the reference does not change.
- R8: The reference never passes the goal. It lands exactly on the goal with the final, shorter step.
- R9: With enable low, the goal is 0. The reference ramps there, and the off flag is high only while enable is low (or an off code is active) and the reference is 0.
- R10: The at-target flag is high only while enabled with a non-off code and the reference equals the decoded target. The off flag and the at-target flag are never both high.
- R11: Code and mode are taken only in a cycle with the load strobe high. Changes on those pins at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Regulation enable; low drives the goal to zero |
| load_i | input | 1 | Capture strobe for code_i and mode_i |
| mode_i | input | 1 | Table select: 0 serial 7-bit, 1 parallel 6-bit |
| code_i | input | 7 | Voltage-identification code |
| tick_i | input | 1 | One-cycle pulse per microsecond; allows one slew step |
| ref_o | output | 12 | Live reference in 0.5 mV units |
| out_off_o | output | 1 | Output is off and the reference has reached zero |
| at_target_o | output | 1 | Reference equals the decoded, active target |

## Verification
The hardest situations to reach from the ports are a redirection in the middle of a ramp, and the final clamped step that lands exactly on a goal. A redirection means a new code, an enable drop or an off code arriving while the reference is still moving, which can reverse the slew direction at an arbitrary fractional position.

The stimulus reaches these situations in two ways. Random loads and enable changes are applied after a random number of ticks, often far fewer than a full ramp needs, so many ramps are cut short and turned around at odd half-unit values. Directed ramps are run to completion, where the remaining gap is almost never a multiple of 13 half-units.

// File: rtl/vid_ref_pkg.sv
package vid_ref_pkg;
  localparam int unsigned CODE_W         = 7;
  localparam int unsigned SER_FULL       = 3100;
  localparam int unsigned SER_STEP       = 25;
  localparam int unsigned SER_OFF_FIRST  = 124;
  localparam int unsigned PAR_FULL       = 3100;
  localparam int unsigned PAR_COARSE     = 50;
  localparam int unsigned PAR_KNEE_CODE  = 32;
  localparam int unsigned PAR_KNEE       = 1525;
  localparam int unsigned PAR_FINE       = 25;

  typedef enum logic {
    VID_SERIAL   = 1'b0,
    VID_PARALLEL = 1'b1
  } vid_mode_e;
endpackage

// File: rtl/vid_ref_decode.sv
module vid_ref_decode
  import vid_ref_pkg::*;
#(
  parameter int unsigned REF_W = 12
) (
  input  logic [CODE_W-1:0] code_i,
  input  vid_mode_e         mode_i,
  output logic [REF_W-1:0]  target_o,
  output logic              off_o
);
  localparam logic [REF_W-1:0] K_SER_FULL  = REF_W'(SER_FULL);
  localparam logic [REF_W-1:0] K_SER_STEP  = REF_W'(SER_STEP);
  localparam logic [REF_W-1:0] K_SER_OFF   = REF_W'(SER_OFF_FIRST);
  localparam logic [REF_W-1:0] K_PAR_FULL  = REF_W'(PAR_FULL);
  localparam logic [REF_W-1:0] K_PAR_CRS   = REF_W'(PAR_COARSE);
  localparam logic [REF_W-1:0] K_KNEE_CODE = REF_W'(PAR_KNEE_CODE);
  localparam logic [REF_W-1:0] K_KNEE      = REF_W'(PAR_KNEE);
  localparam logic [REF_W-1:0] K_PAR_FINE  = REF_W'(PAR_FINE);

  logic [REF_W-1:0] full_code;
  logic [REF_W-1:0] low_code;

  assign full_code = REF_W'(code_i);
  assign low_code  = REF_W'(code_i[5:0]);

  always_comb begin
    off_o    = 1'b0;
    target_o = '0;
    if (mode_i == VID_SERIAL) begin
      if (full_code >= K_SER_OFF) begin
        off_o = 1'b1;
      end else begin
        target_o = K_SER_FULL - full_code * K_SER_STEP;
      end
    end else if (low_code < K_KNEE_CODE) begin
      target_o = K_PAR_FULL - low_code * K_PAR_CRS;
    end else begin
      target_o = K_KNEE - (low_code - K_KNEE_CODE) * K_PAR_FINE;
    end
  end
endmodule

// File: rtl/vid_ref_slew.sv
module vid_ref_slew #(
  parameter int unsigned FX_W      = 13,
  parameter int unsigned STEP_HALF = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [FX_W-1:0] goal_fx_i,
  output logic [FX_W-1:0] ref_fx_o
);
  localparam logic [FX_W-1:0] STEP_FX = FX_W'(STEP_HALF);

  logic [FX_W-1:0] ref_fx_q, ref_fx_d;
  logic [FX_W-1:0] gap_up, gap_dn;

  assign gap_up = goal_fx_i - ref_fx_q;
  assign gap_dn = ref_fx_q - goal_fx_i;

  always_comb begin
    ref_fx_d = ref_fx_q;
    if (tick_i) begin
      if (ref_fx_q < goal_fx_i) begin
        ref_fx_d = (gap_up <= STEP_FX) ? goal_fx_i : ref_fx_q + STEP_FX;
      end else if (ref_fx_q > goal_fx_i) begin
        ref_fx_d = (gap_dn <= STEP_FX) ? goal_fx_i : ref_fx_q - STEP_FX;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_fx_q <= '0;
    else         ref_fx_q <= ref_fx_d;
  end

  assign ref_fx_o = ref_fx_q;

  // R7: no tick, no movement
  p_hold_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ref_fx_q));

  // R6: one tick moves at most one step
  p_step_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (((ref_fx_q >= $past(ref_fx_q)) ? (ref_fx_q - $past(ref_fx_q))
                 : ($past(ref_fx_q) - ref_fx_q)) <= STEP_FX));

  // R8: rising ramp never passes the goal
  p_no_overshoot_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fx_q <= goal_fx_i) |=> (ref_fx_q <= $past(goal_fx_i)));

  // R8: falling ramp never passes the goal
  p_no_overshoot_dn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fx_q >= goal_fx_i) |=> (ref_fx_q >= $past(goal_fx_i)));
endmodule

// File: rtl/vid_ref_ramp.sv
module vid_ref_ramp
  import vid_ref_pkg::*;
#(
  parameter int unsigned REF_W     = 12,
  parameter int unsigned STEP_HALF = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              load_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic [REF_W-1:0]  ref_o,
  output logic              out_off_o,
  output logic              at_target_o
);
  localparam int unsigned FX_W = REF_W + 1;

  logic [CODE_W-1:0] code_q;
  logic              mode_q;
  logic [REF_W-1:0]  target;
  logic              code_off;
  logic              running;
  logic [FX_W-1:0]   goal_fx;
  logic [FX_W-1:0]   ref_fx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else if (load_i) begin
      code_q <= code_i;
      mode_q <= mode_i;
    end
  end

  vid_ref_decode #(.REF_W(REF_W)) u_decode (
    .code_i   (code_q),
    .mode_i   (vid_mode_e'(mode_q)),
    .target_o (target),
    .off_o    (code_off)
  );

  assign running = enable_i && !code_off;
  assign goal_fx = running ? {target, 1'b0} : '0;

  vid_ref_slew #(.FX_W(FX_W), .STEP_HALF(STEP_HALF)) u_slew (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .goal_fx_i (goal_fx),
    .ref_fx_o  (ref_fx)
  );

  assign ref_o       = ref_fx[FX_W-1:1];
  assign out_off_o   = !running && (ref_fx == '0);
  assign at_target_o = running && (ref_fx == goal_fx);

  // R10: flags are mutually exclusive
  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_off_o && at_target_o));

  // R9: off flag implies a zero reference
  p_off_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_off_o |-> (ref_o == '0));

  // R11: captured code and mode hold without a load strobe
  p_code_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(code_q) && $stable(mode_q)));
endmodule

// File: tb/vid_ref_ramp_tb_top.sv
`timescale 1ns/100ps
module vid_ref_ramp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, load = 1'b0, mode = 1'b0, tick = 1'b0;
  logic [6:0] code = '0;
  logic [11:0] ref_v;
  logic off_f, at_f;

  int n_vec = 0;
  int n_err = 0;
  int m_fx = 0;
  int m_code = 0;
  bit m_mode = 1'b0;
  bit m_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vid_ref_ramp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .load_i(load), .mode_i(mode),
    .code_i(code), .tick_i(tick), .ref_o(ref_v), .out_off_o(off_f), .at_target_o(at_f)
  );

  function automatic bit exp_off(int c, bit md);
    return !md && c >= 124;
  endfunction

  function automatic int exp_target(int c, bit md);
    int lo;
    lo = c % 64;
    if (!md) return exp_off(c, md) ? 0 : 3100 - 25 * c;
    if (lo < 32) return 3100 - 50 * lo;
    return 1525 - 25 * (lo - 32);
  endfunction

  function automatic bit m_run();
    return m_en && !exp_off(m_code, m_mode);
  endfunction

  function automatic int m_goal();
    return m_run() ? 2 * exp_target(m_code, m_mode) : 0;
  endfunction

  task automatic chk(string tag, bit ok, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    bit e_at, e_off;
    e_at  = m_run() && (m_fx == m_goal());
    e_off = !m_run() && (m_fx == 0);
    chk(tag, ref_v == 12'(m_fx / 2), int'(ref_v), m_fx / 2);
    chk("R10 at-target", at_f == e_at, int'(at_f), int'(e_at));
    chk("R9 off flag", off_f == e_off, int'(off_f), int'(e_off));
  endtask

  task automatic do_tick(string tag);
    int g;
    @(negedge clk);
    tick = 1'b1;
    g = m_goal();
    if (m_fx < g) m_fx = (g - m_fx <= 13) ? g : m_fx + 13;
    else if (m_fx > g) m_fx = (m_fx - g <= 13) ? g : m_fx - 13;
    @(negedge clk);
    tick = 1'b0;
    check_outs(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      check_outs("R7 hold without tick");
    end
  endtask

  task automatic do_load(int c, bit md);
    @(negedge clk);
    code = 7'(c); mode = md; load = 1'b1;
    m_code = c; m_mode = md;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    en = v; m_en = v;
  endtask

  task automatic settle(string tag, int exp_ref);
    for (int i = 0; i < 700 && m_fx != m_goal(); i++) do_tick("R6 slew step");
    chk(tag, int'(ref_v) == exp_ref, int'(ref_v), exp_ref);
    chk("R8 lands exactly", m_fx == m_goal(), m_fx, m_goal());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1cafe5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 reset state");
    chk("R1 off after reset", off_f == 1'b1, int'(off_f), 1);

    // Soft-start to serial code 0; first steps 6 then 13
    do_load(0, 1'b0);
    set_en(1'b1);
    do_tick("R6 first step");
    chk("R6 first step", ref_v == 12'd6, int'(ref_v), 6);
    do_tick("R6 second step");
    chk("R6 second step", ref_v == 12'd13, int'(ref_v), 13);
    idle(5);
    settle("R2 serial code 0", 3100);
    chk("R10 at-target set", at_f == 1'b1, int'(at_f), 1);

    // Code pins wiggle without load
    @(negedge clk); code = 7'd50; mode = 1'b1;
    repeat (20) do_tick("R11 code ignored without load");
    chk("R11 reference unchanged", ref_v == 12'd3100, int'(ref_v), 3100);

    do_load(123, 1'b0);
    settle("R2 serial code 123", 25);
    do_load(124, 1'b0);
    settle("R3 serial off code ramps to zero", 0);
    chk("R3 off flag", off_f == 1'b1, int'(off_f), 1);
    do_load(127, 1'b1);
    settle("R3 code 127 is live in parallel", 750);
    do_load(31, 1'b1);
    settle("R4 parallel code 31", 1550);
    do_load(5, 1'b1);
    settle("R4 parallel code 5", 2850);
    do_load(32, 1'b1);
    settle("R5 parallel code 32", 1525);
    do_load(63, 1'b1);
    settle("R5 parallel code 63", 750);
    set_en(1'b0);
    settle("R9 disable ramps to zero", 0);
    chk("R9 off flag", off_f == 1'b1, int'(off_f), 1);

    // Random redirection mid-ramp
    for (int it = 0; it < 40; it++) begin
      int c, nt;
      bit md;
      c  = int'($urandom_range(0, 127));
      md = 1'($urandom_range(0, 1));
      do_load(c, md);
      if ($urandom_range(0, 4) == 0) set_en(1'($urandom_range(0, 1)));
      else if (!m_en) set_en(1'b1);
      nt = int'($urandom_range(0, 400));
      for (int k = 0; k < nt; k++) begin
        if ($urandom_range(0, 15) == 0) idle(1);
        do_tick(md ? "R6 random parallel step" : "R6 random serial step");
      end
    end
    settle("R8 random final landing", m_goal() / 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule